// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block counts hardware events in four independent 32-bit up-counters. Each counter has its own control word that picks one line of a 32-bit event pulse vector and sets the conditions under which the counter is held still: an unconditional hold, holds that depend on the current privilege level, and holds that depend on a mark signal from the processor. A single global control word can stop every counter at once. It also enables the interrupt and can make the block stop all counting by itself when an enabled counter reaches its condition.

A counter is in its condition state whenever its most significant bit is set. Software that wants an interrupt after N events loads 0x80000000 minus N, enables that counter's condition, and enables the global interrupt. The interrupt stays raised until software rewrites the counter or clears one of the enables. All registers sit behind a plain read/write port with a 4-bit address. Reads are combinational and have no side effects.

Top module: `pmu_unit`

## Requirements
- R1: After reset every counter reads 0, every local control word reads 0x0000001F (all five hold bits set, condition enable clear, event select 0), the global word reads 0x00000001 (stop-all set) and the interrupt is low.
- R2: A counter that is not held adds exactly one for each cycle in which the event line named by its event-select field (local word bits 12:8) is high. Pulses on any other line leave it unchanged.
- R3: While global bit 0 (stop-all) is set, no counter changes except through a register write, whatever the local words hold.
- R4: While local bit 0 (hold) is set, that counter does not count. Clearing it resumes counting with the event selection unchanged.
- R5: Local bit 1 holds the counter while the privilege input is 1 (supervisor), and local bit 2 holds it while the privilege input is 0 (user).
- R6: Local bit 3 holds the counter while the mark input is 0, and local bit 4 holds it while the mark input is 1.
- R7: A counter's condition is its bit 31. Loading 0x80000000 minus N and counting N events sets bit 31 on the Nth event and not before.
- R8: The interrupt is high exactly when global bit 1 (interrupt enable) is set and at least one counter has both local bit 5 (condition enable) and bit 31 set. It stays high until a write removes that state.
- R9: With global bit 2 (stop on condition) set, the block sets global bit 0 on the clock edge after an enabled counter first shows its condition.
- R10: A register write to a counter in the same cycle as one of its increments loads the written value, and the increment is dropped.
- R11: Address map: 0 to 3 are the counters, 4 to 7 the local words, 8 the global word, and 9 to 15 read as 0. Local words keep only bits 12:8 and 5:0, the global word keeps only bits 2:0, and a read changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 32 | Event pulse vector, one line per event source |
| privSup | input | 1 | 1 while the processor runs in supervisor mode, 0 in user mode |
| markIn | input | 1 | Processor mark signal |
| regAddr | input | 4 | Register address for both read and write |
| regWrEn | input | 1 | Write strobe, active high |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irqOut | output | 1 | Interrupt request, level |

## Verification
A register write or a counted pulse takes effect at the first rising edge after it is driven, and read data and the interrupt follow that edge combinationally. The automatic stop-all comes one edge later, because it is registered from the condition. The bench drives every stimulus at a falling edge and samples a short delay after a falling edge. For the automatic stop it waits one extra cycle before it reads the global word. The hold sweep walks all sixteen combinations of the four gated hold bits against both privilege levels and both mark values on every counter, and computes each expected count from the hold rules.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int PMU_CTRS = 4;

  // local control word bit positions
  localparam int LCW_HOLD    = 0;
  localparam int LCW_FZ_SUP  = 1;
  localparam int LCW_FZ_USR  = 2;
  localparam int LCW_FZ_MK0  = 3;
  localparam int LCW_FZ_MK1  = 4;
  localparam int LCW_CE      = 5;
  localparam int LCW_SEL_LSB = 8;

  // global control word bit positions
  localparam int GC_STOP = 0;
  localparam int GC_IE   = 1;
  localparam int GC_SOC  = 2;

  typedef struct packed {
    logic [PMU_CTRS-1:0] ctrLoad;
    logic [PMU_CTRS-1:0] ctrInc;
  } pmuStrobe_t;
endpackage

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int NumCtr = PMU_CTRS,
  parameter int CtrW   = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pmuStrobe_t                 strb,
  input  logic [CtrW-1:0]            wrData,
  output logic [NumCtr-1:0][CtrW-1:0] ctrVal
);
  localparam logic [CtrW-1:0] One = CtrW'(1);

  for (genvar i = 0; i < NumCtr; i++) begin : gCtr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrVal[i] <= '0;
      end else if (strb.ctrLoad[i]) begin
        ctrVal[i] <= wrData;
      end else if (strb.ctrInc[i]) begin
        ctrVal[i] <= ctrVal[i] + One;
      end
    end

    // R10: a load wins over an increment in the same cycle
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      strb.ctrLoad[i] |=> (ctrVal[i] == $past(wrData)));

    // R2: one increment adds exactly one
    assert_inc_one_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ctrInc[i] && !strb.ctrLoad[i]) |=> (ctrVal[i] == $past(ctrVal[i]) + One));

    // R2: no strobe, no change
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.ctrInc[i] && !strb.ctrLoad[i]) |=> $stable(ctrVal[i]));
  end
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int NumCtr = PMU_CTRS,
  parameter int CtrW   = 32,
  parameter int EvtW   = 32,
  parameter int AddrW  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [EvtW-1:0]             evtIn,
  input  logic                        privSup,
  input  logic                        markIn,
  input  logic [AddrW-1:0]            regAddr,
  input  logic                        regWrEn,
  input  logic [CtrW-1:0]             regWrData,
  input  logic [NumCtr-1:0][CtrW-1:0] ctrVal,
  output pmuStrobe_t                  strb,
  output logic [CtrW-1:0]             regRdData,
  output logic                        irqOut
);
  localparam int SelW    = $clog2(EvtW);
  localparam int LcwBase = NumCtr;
  localparam int GcAddr  = 2 * NumCtr;

  logic [NumCtr-1:0]           hold, fzSup, fzUsr, fzMk0, fzMk1, condEn, msbVec;
  logic [NumCtr-1:0][SelW-1:0] evSel;
  logic [NumCtr-1:0][CtrW-1:0] lcwRd;
  logic                        gStop, gIntEn, gSoc, gWr, anyCond;

  assign gWr = regWrEn && (regAddr == AddrW'(GcAddr));

  for (genvar i = 0; i < NumCtr; i++) begin : gLcw
    logic lcwWr;
    logic gated;
    assign lcwWr = regWrEn && (regAddr == AddrW'(LcwBase + i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hold[i]   <= 1'b1;
        fzSup[i]  <= 1'b1;
        fzUsr[i]  <= 1'b1;
        fzMk0[i]  <= 1'b1;
        fzMk1[i]  <= 1'b1;
        condEn[i] <= 1'b0;
        evSel[i]  <= '0;
      end else if (lcwWr) begin
        hold[i]   <= regWrData[LCW_HOLD];
        fzSup[i]  <= regWrData[LCW_FZ_SUP];
        fzUsr[i]  <= regWrData[LCW_FZ_USR];
        fzMk0[i]  <= regWrData[LCW_FZ_MK0];
        fzMk1[i]  <= regWrData[LCW_FZ_MK1];
        condEn[i] <= regWrData[LCW_CE];
        evSel[i]  <= regWrData[LCW_SEL_LSB +: SelW];
      end
    end

    assign gated = gStop | hold[i]
                 | (privSup & fzSup[i]) | (~privSup & fzUsr[i])
                 | (~markIn & fzMk0[i]) | (markIn & fzMk1[i]);

    assign strb.ctrInc[i]  = evtIn[evSel[i]] & ~gated;
    assign strb.ctrLoad[i] = regWrEn && (regAddr == AddrW'(i));
    assign msbVec[i]       = ctrVal[i][CtrW-1];

    always_comb begin
      lcwRd[i] = '0;
      lcwRd[i][LCW_HOLD]   = hold[i];
      lcwRd[i][LCW_FZ_SUP] = fzSup[i];
      lcwRd[i][LCW_FZ_USR] = fzUsr[i];
      lcwRd[i][LCW_FZ_MK0] = fzMk0[i];
      lcwRd[i][LCW_FZ_MK1] = fzMk1[i];
      lcwRd[i][LCW_CE]     = condEn[i];
      lcwRd[i][LCW_SEL_LSB +: SelW] = evSel[i];
    end
  end

  assign anyCond = |(condEn & msbVec);
  assign irqOut  = gIntEn & anyCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gStop  <= 1'b1;
      gIntEn <= 1'b0;
      gSoc   <= 1'b0;
    end else begin
      if (gWr) begin
        gStop  <= regWrData[GC_STOP];
        gIntEn <= regWrData[GC_IE];
        gSoc   <= regWrData[GC_SOC];
      end
      if (gSoc && anyCond) gStop <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NumCtr; i++) begin
      if (regAddr == AddrW'(i))           regRdData = ctrVal[i];
      if (regAddr == AddrW'(LcwBase + i)) regRdData = lcwRd[i];
    end
    if (regAddr == AddrW'(GcAddr)) begin
      regRdData[GC_STOP] = gStop;
      regRdData[GC_IE]   = gIntEn;
      regRdData[GC_SOC]  = gSoc;
    end
  end

  // R3: stop-all freezes every counter that is not being written
  assert_stop_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    (gStop && !(|strb.ctrLoad)) |=> (ctrVal == $past(ctrVal)));

  // R8: the interrupt holds until a register write
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !regWrEn) |=> irqOut);

  // R9: an enabled condition with stop-on-condition sets stop-all next edge
  assert_auto_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (gSoc && anyCond) |=> gStop);
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
  import pmu_pkg::*;
#(
  parameter int NumCtr = PMU_CTRS,
  parameter int CtrW   = 32,
  parameter int EvtW   = 32,
  parameter int AddrW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EvtW-1:0]  evtIn,
  input  logic             privSup,
  input  logic             markIn,
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWrEn,
  input  logic [CtrW-1:0]  regWrData,
  output logic [CtrW-1:0]  regRdData,
  output logic             irqOut
);
  pmuStrobe_t                  strb;
  logic [NumCtr-1:0][CtrW-1:0] ctrVal;

  pmu_ctrl #(.NumCtr(NumCtr), .CtrW(CtrW), .EvtW(EvtW), .AddrW(AddrW)) uCtrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .privSup(privSup), .markIn(markIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .ctrVal(ctrVal), .strb(strb), .regRdData(regRdData), .irqOut(irqOut)
  );

  pmu_datapath #(.NumCtr(NumCtr), .CtrW(CtrW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData), .ctrVal(ctrVal)
  );
endmodule

// File: tb/sim_pmu_unit.sv
`timescale 1ns/1ps
module sim_pmu_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0;
  logic        privSup = 1'b0;
  logic        markIn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pmu_unit u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .privSup(privSup), .markIn(markIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(regRdData, exp, tag);
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk);
    evtIn = ev;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) rdChk(4'(i), 32'h0, "R1 counter");
    for (int i = 0; i < 4; i++) rdChk(4'(4 + i), 32'h1F, "R1 local word");
    rdChk(4'd8, 32'h1, "R1 global word");
    chk({31'b0, irqOut}, 32'h0, "R1 irq");
    pulse(32'hFFFF_FFFF);
    rdChk(4'd0, 32'h0, "R1 no count after reset");

    // R3 stop-all overrides cleared locals
    for (int i = 0; i < 4; i++) wr(4'(4 + i), 32'h0);
    pulse(32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) rdChk(4'(i), 32'h0, "R3 stop-all");
    wr(4'd8, 32'h0);
    pulse(32'h1);
    for (int i = 0; i < 4; i++) rdChk(4'(i), 32'h1, "R2 count after release");

    // R2 event select sweep on counter 1
    wr(4'd4, 32'h1); wr(4'd6, 32'h1); wr(4'd7, 32'h1);
    for (int k = 0; k < 32; k++) begin
      wr(4'd5, 32'(k) << 8);
      wr(4'd1, 32'h0);
      pulse(~(32'h1 << k));
      rdChk(4'd1, 32'h0, "R2 other lines ignored");
      pulse(32'h1 << k);
      pulse(32'h1 << k);
      rdChk(4'd1, 32'h2, "R2 selected line counted");
    end

    // R4 hold bit
    wr(4'd5, 32'h501);
    wr(4'd1, 32'h0);
    pulse(32'h20);
    rdChk(4'd1, 32'h0, "R4 hold");
    wr(4'd5, 32'h500);
    rdChk(4'd5, 32'h500, "R4 select kept");
    pulse(32'h20);
    rdChk(4'd1, 32'h1, "R4 resume");
    wr(4'd5, 32'h1);

    // R5 R6 sweep: privilege and mark holds on every counter
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 16; f++) begin
        for (int p = 0; p < 2; p++) begin
          for (int m = 0; m < 2; m++) begin
            logic frz;
            frz = (f[0] && p == 1) || (f[1] && p == 0) || (f[2] && m == 0) || (f[3] && m == 1);
            wr(4'(4 + c), (32'(c + 3) << 8) | (32'(f) << 1));
            wr(4'(c), 32'h0);
            privSup = p[0]; markIn = m[0];
            pulse(32'h1 << (c + 3));
            rdChk(4'(c), frz ? 32'h0 : 32'h1, "R5 R6 gated hold");
          end
        end
      end
      wr(4'(4 + c), 32'h1);
    end
    privSup = 1'b0; markIn = 1'b0;

    // R7 R8 condition and interrupt on counter 2
    wr(4'd6, 32'h620);
    wr(4'd8, 32'h2);
    wr(4'd2, 32'h8000_0000 - 32'd5);
    for (int n = 0; n < 4; n++) pulse(32'h40);
    rdChk(4'd2, 32'h7FFF_FFFF, "R7 before Nth event");
    chk({31'b0, irqOut}, 32'h0, "R8 no irq before condition");
    pulse(32'h40);
    rdChk(4'd2, 32'h8000_0000, "R7 Nth event");
    chk({31'b0, irqOut}, 32'h1, "R8 irq raised");
    repeat (5) @(negedge clk);
    #1 chk({31'b0, irqOut}, 32'h1, "R8 irq sticky");
    wr(4'd8, 32'h0);
    #1 chk({31'b0, irqOut}, 32'h0, "R8 global enable off");
    wr(4'd8, 32'h2);
    #1 chk({31'b0, irqOut}, 32'h1, "R8 global enable on");
    wr(4'd6, 32'h600);
    #1 chk({31'b0, irqOut}, 32'h0, "R8 condition enable off");
    rdChk(4'd2, 32'h8000_0000, "R8 counter kept");
    wr(4'd6, 32'h620);
    #1 chk({31'b0, irqOut}, 32'h1, "R8 condition enable on");
    wr(4'd2, 32'h10);
    #1 chk({31'b0, irqOut}, 32'h0, "R8 counter rewrite");
    wr(4'd6, 32'h1);

    // R9 automatic stop-all on counter 3
    wr(4'd7, 32'h720);
    wr(4'd3, 32'h7FFF_FFFF);
    wr(4'd8, 32'h6);
    pulse(32'h80);
    rdChk(4'd3, 32'h8000_0000, "R9 condition reached");
    @(negedge clk);
    rdChk(4'd8, 32'h7, "R9 stop-all set by block");
    chk({31'b0, irqOut}, 32'h1, "R9 irq");
    pulse(32'h80);
    rdChk(4'd3, 32'h8000_0000, "R3 frozen after auto stop");
    wr(4'd3, 32'h0);
    wr(4'd8, 32'h0);
    rdChk(4'd8, 32'h0, "R9 software clear");
    wr(4'd7, 32'h1);

    // R10 write beats increment
    wr(4'd4, 32'h0);
    wr(4'd0, 32'h50);
    @(negedge clk);
    evtIn = 32'h1; regAddr = 4'd0; regWrEn = 1'b1; regWrData = 32'h100;
    @(negedge clk);
    evtIn = '0; regWrEn = 1'b0;
    rdChk(4'd0, 32'h100, "R10 write wins");
    pulse(32'h1);
    rdChk(4'd0, 32'h101, "R10 counting after write");

    // R11 address map and field widths
    for (int a = 9; a < 16; a++) rdChk(4'(a), 32'h0, "R11 unmapped");
    wr(4'd4, 32'hFFFF_FFFF);
    rdChk(4'd4, 32'h1F3F, "R11 local field mask");
    wr(4'd8, 32'hFFFF_FFFF);
    rdChk(4'd8, 32'h7, "R11 global field mask");
    rdChk(4'd0, 32'h101, "R11 read no side effect");
    @(negedge clk);
    rdChk(4'd0, 32'h101, "R11 repeat read");
    wr(4'd8, 32'h1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule